// File: doc/BRIEF.md
# OUT Endpoint Receive Buffer with Bank Ping-Pong

This block buffers the data of one OUT endpoint of a USB device. The bus side delivers the bytes of each incoming data packet, one per cycle, followed by an end-of-packet strobe. The buffer then returns a one-cycle handshake verdict: ACK when the packet was stored, NAK when it was refused. The CPU side pops stored bytes through a single data port and sees the remaining byte count of the bank it is looking at. It also sees a received-packet flag, a bank-held bit and a read-allowed status bit. An interrupt output follows the received-packet flag, gated by an enable input.

The buffer holds either one bank or two banks of `BANK_BYTES` bytes each, selected by `cfg_dual`. With two banks the banks alternate. The host fills one bank while the CPU drains the other, and packets always reach the CPU in arrival order. The CPU acknowledges a packet by writing zero to the received-packet flag. It hands the bank back by writing zero to the bank-held bit, and it must do so in that order. Releasing a bank moves the CPU view to the next bank, and both bits are reloaded from that bank's state.

Top module: `ep_out_rxbuf`

## Requirements
- R1: A packet that targets a free bank and carries at most `BANK_BYTES` bytes is answered with `bus_hs_vld`=1 and `bus_hs_ack`=1 one cycle after `bus_eop`. The bank becomes held, and `cpu_byte_cnt` shows the packet length.
- R2: When a packet is stored into the bank the CPU is viewing, `pkt_flag` goes to 1. `irq` is 1 exactly when `pkt_flag`=1 and `pkt_ie`=1.
- R3: A write strobe on `pkt_flag_we` or `rel_we` with a data value of 1 leaves both bits unchanged. Only a written 0 can clear them.
- R4: A release (`rel_we`=1, `rel_wval`=0) is ignored while `pkt_flag`=1. When `pkt_flag`=0, a release frees the current bank, and `bank_held` and `pkt_flag` take the state of the next bank in the following cycle.
- R5: Each `cpu_rd` pulse while `rd_allow`=1 returns the next byte in arrival order on `cpu_rd_data` one cycle later and decrements `cpu_byte_cnt`. `rd_allow` falls once the count reaches zero.
- R6: A `cpu_rd` pulse while `rd_allow`=0 returns 0 on `cpu_rd_data` and leaves `cpu_byte_cnt` unchanged.
- R7: In one-bank mode (`cfg_dual`=0), a packet that arrives while the bank is held is answered with NAK, and the stored packet is kept intact.
- R8: In two-bank mode, a second packet is accepted while the CPU holds the first. When the first bank is released, `pkt_flag` is 1 at once and the second packet's count and bytes are presented.
- R9: In two-bank mode, a packet that arrives while both banks are held is answered with NAK.
- R10: A packet of more than `BANK_BYTES` bytes is answered with NAK, and the bank stays free. A packet of exactly `BANK_BYTES` bytes is accepted.
- R11: After reset, `pkt_flag`, `bank_held`, `rd_allow`, `irq`, `cpu_byte_cnt` and `bus_hs_vld` are 0. The first packet is stored in bank 0, and the CPU reads bank 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 = two banks, 0 = one bank; changed only during reset |
| bus_byte_vld | input | 1 | Packet byte valid |
| bus_byte | input | DW | Packet byte |
| bus_eop | input | 1 | End-of-packet strobe, in a cycle of its own |
| bus_hs_vld | output | 1 | Handshake verdict valid, one cycle after end of packet |
| bus_hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| cpu_rd | input | 1 | Pop one byte from the current bank |
| cpu_rd_data | output | DW | Popped byte, valid the cycle after `cpu_rd` |
| cpu_byte_cnt | output | $clog2(BANK_BYTES)+1 | Unread bytes in the current bank |
| pkt_flag_we | input | 1 | Write strobe for the received-packet flag |
| pkt_flag_wval | input | 1 | Value written to the flag (only 0 acts) |
| rel_we | input | 1 | Write strobe for the bank-held bit |
| rel_wval | input | 1 | Value written to the bank-held bit (only 0 acts) |
| pkt_ie | input | 1 | Interrupt enable |
| pkt_flag | output | 1 | Received-packet flag |
| bank_held | output | 1 | Current bank holds a packet owned by the CPU |
| rd_allow | output | 1 | Unread data remains in the current bank |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench targets the ping-pong hand-over. A release with a second packet waiting must raise the flag in the same step and present that bank's count and bytes. A design that reloads the flag late or reads the wrong bank shows a zero flag or the first packet's bytes. A release written while the flag is still set is also probed. A design that skips the ordering rule would drop the bank, and `bank_held` would fall.

The bench also drives these boundary cases:
- A packet one byte too long, and one of exactly bank size. An off-by-one overflow test would ACK the long one or NAK the full one.
- A third packet while both banks are held, and a repeat packet in one-bank mode. A design that overwrites here would ACK and change the count.
- Reads on an empty bank, which must return zero without wrapping the count.
- Writes of 1 to either control bit, which must change nothing.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;
  localparam int NBANK = 2;

  typedef enum logic {
    HS_NAK = 1'b0,
    HS_ACK = 1'b1
  } hs_code_e;
endpackage

// File: rtl/ep_rx_ram.sv
// Simple dual-port storage for all banks; registered read for RAM inference.
module ep_rx_ram #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ep_rx_wr.sv
// Bus-side packet writer: byte offset, overflow and refusal tracking, verdict.
module ep_rx_wr #(
  parameter int BANK_BYTES = 16,
  parameter int OFF_W      = 4,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic             eop,
  input  logic             tgt_full,
  output logic             ram_we,
  output logic [OFF_W-1:0] ram_off,
  output logic             commit,
  output logic [CNT_W-1:0] commit_cnt,
  output logic             hs_vld,
  output logic             hs_ack
);
  import ep_rx_pkg::*;

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BANK_BYTES);

  logic             in_pkt;
  logic             blk_q;
  logic             ovf_q;
  logic [CNT_W-1:0] wcnt;
  logic             blk_now;
  logic             room;

  // refusal is decided on the bank state seen at the first byte
  assign blk_now    = in_pkt ? blk_q : tgt_full;
  assign room       = (wcnt < LIMIT);
  assign ram_we     = byte_vld & ~blk_now & room;
  assign ram_off    = wcnt[OFF_W-1:0];
  assign commit     = eop & ~blk_now & ~ovf_q;
  assign commit_cnt = wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      blk_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wcnt   <= '0;
      hs_vld <= 1'b0;
      hs_ack <= HS_NAK;
    end else if (eop) begin
      in_pkt <= 1'b0;
      blk_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wcnt   <= '0;
      hs_vld <= 1'b1;
      hs_ack <= commit ? HS_ACK : HS_NAK;
    end else begin
      hs_vld <= 1'b0;
      hs_ack <= HS_NAK;
      if (byte_vld) begin
        in_pkt <= 1'b1;
        if (!in_pkt) blk_q <= tgt_full;
        if (room) wcnt  <= wcnt + 1'b1;
        else      ovf_q <= 1'b1;
      end
    end
  end

  a_r1_verdict_follows_eop: assert property (@(posedge clk) disable iff (rst)
    eop |=> hs_vld);
  a_r10_overflow_nak: assert property (@(posedge clk) disable iff (rst)
    (eop && ovf_q) |=> (hs_vld && !hs_ack));
  a_r7_held_bank_nak: assert property (@(posedge clk) disable iff (rst)
    (eop && !in_pkt && tgt_full) |=> (hs_vld && !hs_ack));
endmodule

// File: rtl/ep_rx_banks.sv
// Per-bank full/count state and the write/read ping-pong pointers.
module ep_rx_banks #(
  parameter int BANK_BYTES = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_cnt,
  input  logic             release_i,
  output logic             wp,
  output logic             rp,
  output logic             wp_full,
  output logic             rp_full,
  output logic             nxt_full,
  output logic [CNT_W-1:0] rp_cnt
);
  import ep_rx_pkg::*;

  logic [NBANK-1:0] full_v;
  logic [CNT_W-1:0] cnt_v [NBANK];
  logic             nxt;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             f_q;
    logic [CNT_W-1:0] c_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        f_q <= 1'b0;
        c_q <= '0;
      end else if (commit && (wp == 1'(b))) begin
        f_q <= 1'b1;
        c_q <= commit_cnt;
      end else if (release_i && (rp == 1'(b))) begin
        f_q <= 1'b0;
      end
    end

    assign full_v[b] = f_q;
    assign cnt_v[b]  = c_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= 1'b0;
      rp <= 1'b0;
    end else begin
      if (commit)    wp <= wp ^ dual;
      if (release_i) rp <= rp ^ dual;
    end
  end

  assign nxt      = rp ^ dual;
  assign wp_full  = full_v[wp];
  assign rp_full  = full_v[rp];
  assign rp_cnt   = cnt_v[rp];
  assign nxt_full = dual & (full_v[nxt] | (commit & (wp == nxt)));

  a_r9_no_commit_into_full: assert property (@(posedge clk) disable iff (rst)
    commit |-> !wp_full);
  a_r8_release_swaps_bank: assert property (@(posedge clk) disable iff (rst)
    (release_i && dual) |=> (rp != $past(rp)));
  a_r11_single_uses_bank0: assert property (@(posedge clk) disable iff (rst)
    !dual |-> (!wp && !rp));
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
    rp_full |-> (rp_cnt <= CNT_W'(BANK_BYTES)));
endmodule

// File: rtl/ep_out_rxbuf.sv
// Top: OUT endpoint receive buffer, one or two banks.
module ep_out_rxbuf #(
  parameter int BANK_BYTES = 16,
  parameter int DW         = 8,
  localparam int OFF_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_dual,
  input  logic             bus_byte_vld,
  input  logic [DW-1:0]    bus_byte,
  input  logic             bus_eop,
  output logic             bus_hs_vld,
  output logic             bus_hs_ack,
  input  logic             cpu_rd,
  output logic [DW-1:0]    cpu_rd_data,
  output logic [CNT_W-1:0] cpu_byte_cnt,
  input  logic             pkt_flag_we,
  input  logic             pkt_flag_wval,
  input  logic             rel_we,
  input  logic             rel_wval,
  input  logic             pkt_ie,
  output logic             pkt_flag,
  output logic             bank_held,
  output logic             rd_allow,
  output logic             irq
);
  localparam int AW = OFF_W + 1;

  logic             ram_we;
  logic [OFF_W-1:0] ram_off;
  logic             commit;
  logic [CNT_W-1:0] commit_cnt;
  logic             wp, rp;
  logic             wp_full, rp_full, nxt_full;
  logic [CNT_W-1:0] rp_cnt;
  logic             release_w;
  logic             rd_fire;
  logic [CNT_W-1:0] rdcnt;
  logic [CNT_W-1:0] remain;
  logic             rd_vld_q;
  logic [DW-1:0]    ram_q;
  logic             flag_q;

  ep_rx_wr #(.BANK_BYTES(BANK_BYTES), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .byte_vld(bus_byte_vld), .eop(bus_eop),
    .tgt_full(wp_full), .ram_we(ram_we), .ram_off(ram_off),
    .commit(commit), .commit_cnt(commit_cnt),
    .hs_vld(bus_hs_vld), .hs_ack(bus_hs_ack)
  );

  ep_rx_banks #(.BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W)) u_banks (
    .clk(clk), .rst(rst), .dual(cfg_dual), .commit(commit),
    .commit_cnt(commit_cnt), .release_i(release_w),
    .wp(wp), .rp(rp), .wp_full(wp_full), .rp_full(rp_full),
    .nxt_full(nxt_full), .rp_cnt(rp_cnt)
  );

  ep_rx_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr({wp, ram_off}), .wdata(bus_byte),
    .re(rd_fire), .raddr({rp, rdcnt[OFF_W-1:0]}), .rdata(ram_q)
  );

  assign remain    = rp_full ? (rp_cnt - rdcnt) : '0;
  assign rd_allow  = (remain != '0);
  assign rd_fire   = cpu_rd & rd_allow;
  assign release_w = rel_we & ~rel_wval & ~flag_q & rp_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdcnt    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_fire;
      if (release_w)    rdcnt <= '0;
      else if (rd_fire) rdcnt <= rdcnt + 1'b1;
    end
  end

  // flag: reload on bank hand-over, set on arrival into viewed bank, else clear by 0
  always_ff @(posedge clk) begin
    if (rst)                                flag_q <= 1'b0;
    else if (release_w)                     flag_q <= nxt_full;
    else if (commit && (wp == rp))          flag_q <= 1'b1;
    else if (pkt_flag_we && !pkt_flag_wval) flag_q <= 1'b0;
  end

  assign cpu_rd_data  = rd_vld_q ? ram_q : '0;
  assign cpu_byte_cnt = remain;
  assign pkt_flag     = flag_q;
  assign bank_held    = rp_full;
  assign irq          = flag_q & pkt_ie;

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !rd_allow) |=> (cpu_rd_data == '0));
  a_r5_pop_decrements: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && rd_allow && !rel_we) |=> (cpu_byte_cnt == $past(cpu_byte_cnt) - 1'b1));
  a_r4_held_while_flag: assert property (@(posedge clk) disable iff (rst)
    (pkt_flag && bank_held) |=> bank_held);
  a_r2_flag_means_held: assert property (@(posedge clk) disable iff (rst)
    pkt_flag |-> bank_held);
endmodule

// File: tb/ep_out_rxbuf_tb_top.sv
module ep_out_rxbuf_tb_top;
  localparam int PERIOD = 10;
  localparam int BB     = 16;
  localparam int CW     = $clog2(BB) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_dual = 1'b0;
  logic          bus_byte_vld = 1'b0;
  logic [7:0]    bus_byte = '0;
  logic          bus_eop = 1'b0;
  logic          bus_hs_vld, bus_hs_ack;
  logic          cpu_rd = 1'b0;
  logic [7:0]    cpu_rd_data;
  logic [CW-1:0] cpu_byte_cnt;
  logic          pkt_flag_we = 1'b0, pkt_flag_wval = 1'b0;
  logic          rel_we = 1'b0, rel_wval = 1'b0;
  logic          pkt_ie = 1'b1;
  logic          pkt_flag, bank_held, rd_allow, irq;

  int errs = 0;
  int checks = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  ep_out_rxbuf #(.BANK_BYTES(BB), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_dual(cfg_dual),
    .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .bus_eop(bus_eop),
    .bus_hs_vld(bus_hs_vld), .bus_hs_ack(bus_hs_ack),
    .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data), .cpu_byte_cnt(cpu_byte_cnt),
    .pkt_flag_we(pkt_flag_we), .pkt_flag_wval(pkt_flag_wval),
    .rel_we(rel_we), .rel_wval(rel_wval), .pkt_ie(pkt_ie),
    .pkt_flag(pkt_flag), .bank_held(bank_held), .rd_allow(rd_allow), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: sends a packet and queues the expected verdict
  task automatic send_pkt(input int n, input int base, input bit ack, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_byte_vld = 1'b1;
      bus_byte     = 8'(base + i);
    end
    @(negedge clk);
    bus_byte_vld = 1'b0;
    bus_eop      = 1'b1;
    exp_q.push_back(ack);
    tag_q.push_back(req);
    @(negedge clk);
    bus_eop = 1'b0;
  endtask

  // monitor: compares each verdict against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && bus_hs_vld) begin
      if (exp_q.size() == 0) begin
        chk("hs-unexpected", 1, 0);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, int'(bus_hs_ack), int'(e));
      end
    end
  end

  task automatic rd_byte(input int exp, input string req);
    @(negedge clk);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    chk(req, int'(cpu_rd_data), exp);
  endtask

  task automatic wr_flag(input bit v);
    @(negedge clk);
    pkt_flag_we = 1'b1;
    pkt_flag_wval = v;
    @(negedge clk);
    pkt_flag_we = 1'b0;
  endtask

  task automatic wr_rel(input bit v);
    @(negedge clk);
    rel_we = 1'b1;
    rel_wval = v;
    @(negedge clk);
    rel_we = 1'b0;
  endtask

  task automatic do_reset(input bit dual);
    @(negedge clk);
    rst = 1'b1;
    cfg_dual = dual;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // R11 reset state
    chk("R11 flag", int'(pkt_flag), 0);
    chk("R11 held", int'(bank_held), 0);
    chk("R11 rd_allow", int'(rd_allow), 0);
    chk("R11 irq", int'(irq), 0);
    chk("R11 cnt", int'(cpu_byte_cnt), 0);
    chk("R11 hs", int'(bus_hs_vld), 0);

    // R1 / R2 single bank accept
    send_pkt(5, 8'h10, 1'b1, "R1 ack");
    chk("R1 held", int'(bank_held), 1);
    chk("R1 cnt", int'(cpu_byte_cnt), 5);
    chk("R2 flag", int'(pkt_flag), 1);
    chk("R2 irq", int'(irq), 1);
    // R7 held bank refuses
    send_pkt(3, 8'h90, 1'b0, "R7 nak");
    chk("R7 cnt kept", int'(cpu_byte_cnt), 5);
    // R3 writes of one ignored
    wr_flag(1'b1);
    chk("R3 flag", int'(pkt_flag), 1);
    wr_rel(1'b1);
    chk("R3 held", int'(bank_held), 1);
    // R4 release before flag clear ignored
    wr_rel(1'b0);
    chk("R4 held", int'(bank_held), 1);
    chk("R4 cnt", int'(cpu_byte_cnt), 5);
    // R2 enable gating
    pkt_ie = 1'b0;
    #1 chk("R2 irq gated", int'(irq), 0);
    pkt_ie = 1'b1;
    wr_flag(1'b0);
    chk("R2 flag cleared", int'(pkt_flag), 0);
    chk("R2 irq low", int'(irq), 0);
    // R5 pop sequence, R7 data intact
    for (int i = 0; i < 5; i++) begin
      rd_byte(8'h10 + i, "R5 data");
      chk("R5 cnt", int'(cpu_byte_cnt), 4 - i);
    end
    chk("R5 rd_allow", int'(rd_allow), 0);
    chk("R5 held", int'(bank_held), 1);
    // R6 empty read
    rd_byte(0, "R6 data");
    chk("R6 cnt", int'(cpu_byte_cnt), 0);
    // R4 proper release
    wr_rel(1'b0);
    chk("R4 released", int'(bank_held), 0);
    chk("R4 flag", int'(pkt_flag), 0);
    // R10 overflow and exact fit
    send_pkt(BB + 1, 8'h20, 1'b0, "R10 over nak");
    chk("R10 free", int'(bank_held), 0);
    chk("R10 flag", int'(pkt_flag), 0);
    send_pkt(BB, 8'h40, 1'b1, "R10 exact ack");
    chk("R10 cnt", int'(cpu_byte_cnt), BB);
    rd_byte(8'h40, "R10 data");
    wr_flag(1'b0);
    wr_rel(1'b0);
    chk("R10 released", int'(bank_held), 0);

    // two-bank mode
    do_reset(1'b1);
    chk("R11 dual cnt", int'(cpu_byte_cnt), 0);
    send_pkt(4, 8'h50, 1'b1, "R8 first ack");
    send_pkt(6, 8'h60, 1'b1, "R8 second ack");
    send_pkt(2, 8'h70, 1'b0, "R9 both held nak");
    chk("R11 reads bank0 first", int'(cpu_byte_cnt), 4);
    rd_byte(8'h50, "R11 bank0 data");
    wr_flag(1'b0);
    rd_byte(8'h51, "R5 data dual");
    wr_rel(1'b0);
    chk("R8 flag at once", int'(pkt_flag), 1);
    chk("R8 held", int'(bank_held), 1);
    chk("R8 cnt", int'(cpu_byte_cnt), 6);
    for (int i = 0; i < 6; i++) rd_byte(8'h60 + i, "R8 data");
    wr_flag(1'b0);
    wr_rel(1'b0);
    chk("R8 all free", int'(bank_held), 0);
    chk("R8 flag off", int'(pkt_flag), 0);
    send_pkt(2, 8'h80, 1'b1, "R8 wrap ack");
    chk("R8 wrap flag", int'(pkt_flag), 1);
    chk("R8 wrap cnt", int'(cpu_byte_cnt), 2);
    rd_byte(8'h80, "R8 wrap data");

    repeat (3) @(negedge clk);
    chk("hs queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule